// File: doc/BRIEF.md
# Cache-Allocate Store Backup Queue

This block keeps an ordered list of pending stores made by cache-allocating store instructions. Each entry pairs a full address with one data word. The instruction side drives three commands over a single command port. A record command appends a store when the cacheability input marks its address as cached. A discard command drops every entry. A line-invalidate command looks for the oldest entry that falls in the same 32-byte line as the given address.

When an invalidate finds a match, the matching entry is replayed to memory as one 32-bit write on a valid/ready port. Once memory accepts the write, the entry is removed. Entries younger than the removed one then slide down one slot per cycle, so the queue stays in arrival order. While the write is pending and while this compaction runs, a busy output tells the command source to hold off. An invalidate that finds no match finishes at once, with no memory traffic.

Top module: `store_backup_queue`

## Requirements
- R1: After reset the queue is empty, and `busy`, `memWrValid` and `overflow` are all 0.
- R2: A record command (`cmdOp` = 2'b00) appends its address/data pair at the tail only when `cmdCacheable` is 1. When `cmdCacheable` is 0 the queue is left unchanged, so a later invalidate of that line produces no write.
- R3: When several entries share a line, an invalidate acts only on the oldest of them. The younger entries stay queued in their original order.
- R4: An invalidate (`cmdOp` = 2'b10) compares addresses with bits [4:0] ignored. Any byte offset within the 32-byte line matches.
- R5: An invalidate with a match raises `memWrValid` in the cycle after the command. It presents the entry's stored address and data, and holds both stable until `memWrReady` is 1. The entry is removed once memory accepts the write.
- R6: An invalidate with no matching entry issues no write and never raises `busy`.
- R7: A discard command (`cmdOp` = 2'b01) empties the queue and issues no memory write.
- R8: After an entry is removed, later records are appended directly behind the remaining entries. This holds when the removed entry was the newest one.
- R9: The queue holds 8 entries. A cacheable record while the queue is full is dropped and sets the sticky `overflow` output. Only a discard or a reset clears `overflow`.
- R10: Suppose the entry at position k, counted from the oldest as 0, in a queue of n entries is written out. After the write-accepting edge, `busy` stays 1 for exactly n-1-k further cycles, and then falls.
- R11: Commands are taken only while `busy` is 0. `cmdOp` = 2'b11 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe, taken when busy is 0 |
| cmdOp | input | 2 | 00 record, 01 discard, 10 line invalidate, 11 none |
| cmdAddr | input | 32 | Store address or invalidate address |
| cmdData | input | 32 | Store data for a record command |
| cmdCacheable | input | 1 | Cacheability of cmdAddr for a record command |
| busy | output | 1 | Write pending or compaction in progress |
| overflow | output | 1 | Sticky flag for a record dropped because the queue was full |
| memWrValid | output | 1 | Memory write request |
| memWrReady | input | 1 | Memory accepts the write |
| memWrAddr | output | 32 | Write address |
| memWrData | output | 32 | Write data |

## Verification
The bench drives and samples on the falling edge. A record or discard therefore shows its effect at the next falling edge. A matching invalidate raises the write request one edge after the command. The bench checks the address and data there, and again after each stalled cycle of `memWrReady`. After the accepting edge, the bench counts the falling edges that still show `busy` and compares the count with n-1-k from its own ordered model of the queue. Queue contents are never read directly. They are recovered through the writes that later invalidates produce. The sweep covers every queue length from 1 to 8, with pairs of entries sharing a line.

// File: rtl/sbq_pkg.sv
package sbq_pkg;
  typedef enum logic [1:0] {
    OP_RECORD  = 2'b00,
    OP_DISCARD = 2'b01,
    OP_INVAL   = 2'b10,
    OP_NONE    = 2'b11
  } sbqOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic append;  // push command pair at tail
    logic clear;   // drop all entries and overflow
    logic ovfSet;  // record attempted while full
    logic grab;    // latch matching index into pointer
    logic shift;   // move entry ptr+1 into ptr, advance ptr
    logic pop;     // shrink count by one
  } sbqStrobe_t;
endpackage

// File: rtl/sbq_datapath.sv
module sbq_datapath import sbq_pkg::*; #(
  parameter int DEPTH     = 8,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LINE_BITS = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  sbqStrobe_t    stb,
  input  logic [AW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdData,
  output logic          hitAny,
  output logic          full,
  output logic          tailHit,
  output logic          lastShift,
  output logic          overflow,
  output logic [AW-1:0] headAddr,
  output logic [DW-1:0] headData
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [AW-1:0]    addrQ [DEPTH];
  logic [DW-1:0]    dataQ [DEPTH];
  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] ptr;
  logic [DEPTH-1:0] lineHit;
  logic [IDX_W-1:0] hitIdx;
  logic [IDX_W-1:0] ptrNext;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gCmp
      assign lineHit[g] = (CNT_W'(g) < count) &&
        (addrQ[g][AW-1:LINE_BITS] == cmdAddr[AW-1:LINE_BITS]);
    end
  endgenerate

  // oldest match wins: scan from the newest position downward
  always_comb begin
    hitIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (lineHit[i]) hitIdx = IDX_W'(i);
    end
  end

  assign hitAny    = |lineHit;
  assign full      = (count == CNT_W'(DEPTH));
  assign tailHit   = (CNT_W'(ptr) + CNT_W'(1)) == count;
  assign lastShift = (CNT_W'(ptr) + CNT_W'(2)) == count;
  assign ptrNext   = ptr + IDX_W'(1);
  assign headAddr  = addrQ[ptr];
  assign headData  = dataQ[ptr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      ptr      <= '0;
      overflow <= 1'b0;
    end else begin
      if (stb.clear) begin
        count    <= '0;
        overflow <= 1'b0;
      end else if (stb.append) begin
        count <= count + CNT_W'(1);
      end else if (stb.pop) begin
        count <= count - CNT_W'(1);
      end
      if (stb.ovfSet) overflow <= 1'b1;
      if (stb.grab) ptr <= hitIdx;
      else if (stb.shift) ptr <= ptrNext;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.append) begin
      addrQ[IDX_W'(count)] <= cmdAddr;
      dataQ[IDX_W'(count)] <= cmdData;
    end else if (stb.shift) begin
      addrQ[ptr] <= addrQ[ptrNext];
      dataQ[ptr] <= dataQ[ptrNext];
    end
  end

  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R7
  discard_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (count == '0 && !overflow));
  // R2
  append_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.append |=> (count == $past(count) + CNT_W'(1)));
  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(full));
endmodule

// File: rtl/sbq_control.sv
module sbq_control import sbq_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdOp,
  input  logic          cmdCacheable,
  input  logic          hitAny,
  input  logic          full,
  input  logic          tailHit,
  input  logic          lastShift,
  input  logic          memWrReady,
  input  logic [AW-1:0] memWrAddr,
  input  logic [DW-1:0] memWrData,
  output logic          memWrValid,
  output logic          busy,
  output sbqStrobe_t    stb
);
  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_COMPACT} state_e;
  state_e state, stateNext;
  logic   take;

  assign take       = cmdValid && (state == S_IDLE);
  assign busy       = (state != S_IDLE);
  assign memWrValid = (state == S_WRITE);

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (take) begin
          unique case (sbqOp_e'(cmdOp))
            OP_RECORD: begin
              stb.append = cmdCacheable && !full;
              stb.ovfSet = cmdCacheable && full;
            end
            OP_DISCARD: stb.clear = 1'b1;
            OP_INVAL: if (hitAny) begin
              stb.grab  = 1'b1;
              stateNext = S_WRITE;
            end
            default: ;
          endcase
        end
      end
      S_WRITE: begin
        if (memWrReady) begin
          if (tailHit) begin
            stb.pop   = 1'b1;
            stateNext = S_IDLE;
          end else begin
            stateNext = S_COMPACT;
          end
        end
      end
      S_COMPACT: begin
        stb.shift = 1'b1;
        if (lastShift) begin
          stb.pop   = 1'b1;
          stateNext = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && !memWrReady) |=>
      (memWrValid && $stable(memWrAddr) && $stable(memWrData)));
  // R6
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (take && cmdOp == OP_INVAL && !hitAny) |=> !busy);
  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(stb.append || stb.clear || stb.grab));
endmodule

// File: rtl/store_backup_queue.sv
module store_backup_queue import sbq_pkg::*; #(
  parameter int DEPTH     = 8,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LINE_BITS = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdOp,
  input  logic [AW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdData,
  input  logic          cmdCacheable,
  output logic          busy,
  output logic          overflow,
  output logic          memWrValid,
  input  logic          memWrReady,
  output logic [AW-1:0] memWrAddr,
  output logic [DW-1:0] memWrData
);
  sbqStrobe_t stb;
  logic hitAny, full, tailHit, lastShift;

  sbq_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .LINE_BITS(LINE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .hitAny(hitAny), .full(full), .tailHit(tailHit), .lastShift(lastShift),
    .overflow(overflow), .headAddr(memWrAddr), .headData(memWrData)
  );

  sbq_control #(.AW(AW), .DW(DW)) u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdCacheable(cmdCacheable), .hitAny(hitAny), .full(full),
    .tailHit(tailHit), .lastShift(lastShift), .memWrReady(memWrReady),
    .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrValid(memWrValid), .busy(busy), .stb(stb)
  );
endmodule

// File: tb/store_backup_queue_tb.sv
module store_backup_queue_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b11;
  logic [31:0] cmdAddr = '0;
  logic [31:0] cmdData = '0;
  logic cmdCacheable = 1'b0;
  logic memWrReady = 1'b0;
  logic busy, overflow, memWrValid;
  logic [31:0] memWrAddr, memWrData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [31:0] mA [8];
  logic [31:0] mD [8];
  int mN = 0;
  logic ovfExp = 1'b0;

  always #2 clk = ~clk;

  store_backup_queue u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdCacheable(cmdCacheable),
    .busy(busy), .overflow(overflow), .memWrValid(memWrValid),
    .memWrReady(memWrReady), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] d, input logic c);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d; cmdCacheable = c;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b11;
  endtask

  task automatic doRec(input logic [31:0] a, input logic [31:0] d, input logic c);
    issue(2'b00, a, d, c);
    if (c && mN < 8) begin mA[mN] = a; mD[mN] = d; mN++; end
    else if (c) ovfExp = 1'b1;
    // R9 overflow flag
    check(overflow == ovfExp, "R9 overflow", 32'(overflow), 32'(ovfExp));
  endtask

  task automatic doDiscard();
    issue(2'b01, '0, '0, 1'b0);
    mN = 0; ovfExp = 1'b0;
    // R7 no write, overflow cleared
    check(!memWrValid && !busy && !overflow, "R7 discard",
          {29'b0, memWrValid, busy, overflow}, 32'h0);
  endtask

  task automatic doInval(input logic [31:0] a, input int stall);
    int k = -1;
    int cnt = 0;
    for (int i = mN - 1; i >= 0; i--)
      if (mA[i][31:5] == a[31:5]) k = i;
    issue(2'b10, a, '0, 1'b0);
    if (k < 0) begin
      // R6 miss: no write, no busy
      check(!memWrValid && !busy, "R6 miss quiet", {30'b0, memWrValid, busy}, 32'h0);
    end else begin
      // R3 R4 R5 oldest line match presented
      check(memWrValid, "R5 write valid", 32'(memWrValid), 32'h1);
      check(memWrAddr == mA[k], "R3 R4 write addr", memWrAddr, mA[k]);
      check(memWrData == mD[k], "R3 R5 write data", memWrData, mD[k]);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check(memWrValid && memWrAddr == mA[k] && memWrData == mD[k],
              "R5 hold under stall", memWrData, mD[k]);
      end
      memWrReady = 1'b1;
      @(negedge clk);
      memWrReady = 1'b0;
      while (busy) begin cnt++; @(negedge clk); end
      // R10 compaction length
      check(cnt == mN - 1 - k, "R10 busy cycles", 32'(cnt), 32'(mN - 1 - k));
      check(!memWrValid, "R5 write dropped", 32'(memWrValid), 32'h0);
      for (int i = k; i < mN - 1; i++) begin mA[i] = mA[i+1]; mD[i] = mD[i+1]; end
      mN--;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !memWrValid && !overflow, "R1 reset",
          {29'b0, busy, memWrValid, overflow}, 32'h0);
    doInval(32'h1000_0000, 0);

    // sweep all queue lengths; pairs of entries share a line
    for (int n = 1; n <= 8; n++) begin
      doDiscard();
      for (int i = 0; i < n; i++) begin
        doRec(32'h1000_0000 + 32'(n) * 32'h400 + 32'(i / 2) * 32 + 32'(i % 2) * 8,
              32'hD000_0000 + 32'(n) * 256 + 32'(i), 1'b1);
        // R2 non-cacheable record ignored
        if (i == 0) doRec(32'h2000_0000 + 32'(n) * 32, 32'hBAD0_0000, 1'b0);
        // R11 null op does nothing
        if (i == 1) issue(2'b11, 32'h1000_0000 + 32'(n) * 32'h400, '0, 1'b1);
      end
      doInval(32'h2000_0000 + 32'(n) * 32 + 32'h1c, 0);  // R2 check via miss
      for (int j = 0; j < n; j++)
        doInval(32'h1000_0000 + 32'(n) * 32'h400 + 32'(((j * 3) % n) / 2) * 32 + 32'h1f, j % 3);
      while (mN > 0) doInval(mA[0] ^ 32'h0c, 1);
    end

    // R8 tail moves back after newest removed
    doDiscard();
    doRec(32'h3000_0000, 32'hA0, 1'b1);
    doRec(32'h3000_0020, 32'hA1, 1'b1);
    doRec(32'h3000_0040, 32'hA2, 1'b1);
    doInval(32'h3000_0044, 0);
    doRec(32'h3000_0060, 32'hA3, 1'b1);
    doRec(32'h3000_0040, 32'hA4, 1'b1);
    doInval(32'h3000_0060, 2);  // R8 new record at slot 2
    doInval(32'h3000_0040, 0);  // R8
    doInval(32'h3000_0000, 0);

    // R9 overflow when full
    doDiscard();
    for (int i = 0; i < 9; i++) doRec(32'h4000_0000 + 32'(i) * 32, 32'hC0 + 32'(i), 1'b1);
    doInval(32'h4000_0100, 0);  // R9 dropped ninth record: miss
    doRec(32'h5000_0000, 32'h1, 1'b1);  // R9 still full, flag stays
    doDiscard();
    doInval(32'h4000_0000, 0);  // R7 emptied: miss

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule